// File: doc/BRIEF.md
# Straight-Line Single-Cycle Bypass Controller

This block sits inside one mesh router. It decides, each cycle and for each straight-through direction, whether a flit coming from upstream may pass this router without being latched. Per direction it does three things. It turns the local output-arbitration winner into a bypass request. It relays the requests of up to `HPC_MAX-1` upstream senders to the next router. It registers a bypass flag that steers the flit in the following cycle, which is the multi-hop traversal cycle.

A request is a thermometer vector of `HPC_MAX-1` bits, filled with 1s from the MSB. Each 1 asks one more router downstream to let the flit through. Requests travel in slots. Slot k on a link holds the request of the sender k+1 hops upstream. At every router the slots move up by one, the farthest slot is dropped, and each relayed vector is shifted left by one bit. The MSB of an arriving vector therefore tells this router whether that sender wants to pass it. Locally buffered flits always win the output over a bypassing flit. Turns and the flit datapath are outside this block.

There are four direction slices, selected by index d: 0 west-to-east, 1 east-to-west, 2 north-to-south, 3 south-to-north. Slice d takes bits `[d*SW +: SW]` of the slot buses, where `SW=(HPC_MAX-1)*(HPC_MAX-1)`. Within a slice, slot k takes bits `[k*(HPC_MAX-1) +: HPC_MAX-1]`.

Top module: `bypass_ctrl`

## Requirements
- R1: The request generated in slice d is n 1s starting from the MSB, with n = min(hops, HPC_MAX) - 1 and n = 0 when hops is 0. For example, with HPC_MAX=4: hops 1 gives 000, hops 3 gives 110, and hops 4 or more gives 111.
- R2: When a slice has no output-arbitration winner, its outgoing slot 0 is all zeros.
- R3: Outgoing slot 0 carries the request generated in this router. Outgoing slot k (k >= 1) carries incoming slot k-1 shifted left by one bit with a 0 entering at the LSB. Both relations hold combinationally in the same cycle.
- R4: An incoming request in slot k has its k lowest bits at 0. The request in the farthest incoming slot is used only for its MSB and never appears on any outgoing slot.
- R5: The bypass flag of a slice rises on the clock edge that ends a cycle in which at least one incoming slot had its MSB at 1, the downstream free-VC input was 1 and the local request input was 0.
- R6: If a local flit requests the output in that cycle, the flag is 0 in the next cycle, whatever the incoming requests are.
- R7: If the downstream free-VC input is 0, the flag is 0 in the next cycle.
- R8: If no incoming slot has its MSB at 1, the flag is 0 in the next cycle.
- R9: After a synchronous active-high reset, all bypass flags are 0.
- R10: The four slices are independent. Inputs of one direction change only that direction's outgoing slots and flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ssr_in | input | NDIR*SW | Incoming request slots, one group per direction |
| win_valid | input | NDIR | A local flit won output arbitration for this direction |
| hops_left | input | NDIR*HOP_W | Remaining hops in the dimension for that winner |
| local_req | input | NDIR | A locally buffered flit requests this output port |
| free_vc | input | NDIR | The next router has a free VC on this output |
| ssr_out | output | NDIR*SW | Outgoing request slots toward the next router |
| bypass_flag | output | NDIR | Registered bypass flag per direction |

## Verification
The bench sweeps hop counts across the saturation point `HPC_MAX`. A clamp off by one there would either emit a request reaching one router too far or never request the full reach. The bench loads legal patterns into every slot and checks that each relayed vector moves up exactly one slot and left exactly one bit. A design that forgot the bit shift would make every downstream router believe it is being bypassed, and one that kept the farthest slot would leak a stale request past the fixed latching point. Each of the three flag conditions is removed in turn while the other two are held, so that a flag that ignores the local priority or the free-VC input shows up. Finally, only one direction is excited at a time, to catch slices that have been cross-wired.

// File: rtl/bypass_pkg.sv
package bypass_pkg;
  localparam int unsigned NUM_DIRS = 4;
  typedef enum logic [1:0] {
    DIR_WE = 2'd0,
    DIR_EW = 2'd1,
    DIR_NS = 2'd2,
    DIR_SN = 2'd3
  } dir_e;
endpackage

// File: rtl/bypass_req_gen.sv
module bypass_req_gen #(
  parameter int HPC_MAX = 4,
  parameter int HOP_W   = 4,
  localparam int VW     = HPC_MAX - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             win_valid,
  input  logic [HOP_W-1:0] hops_left,
  output logic [VW-1:0]    req_out
);
  int n_pass;

  always_comb begin
    if (!win_valid || hops_left == '0)
      n_pass = 0;
    else if (int'(hops_left) >= HPC_MAX)
      n_pass = VW;
    else
      n_pass = int'(hops_left) - 1;
    for (int i = 0; i < VW; i++)
      req_out[VW-1-i] = (i < n_pass);
  end

  logic [VW-1:0] inv_c, thermo_c;
  assign inv_c    = ~req_out;
  assign thermo_c = (inv_c + VW'(1)) & inv_c;

  AST_REQ_THERMO: assert property (@(posedge clk) disable iff (rst)
    thermo_c == '0); // R1
  AST_REQ_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (win_valid && int'(hops_left) >= HPC_MAX) |-> (&req_out)); // R1
  AST_NO_WIN_ZERO: assert property (@(posedge clk) disable iff (rst)
    !win_valid |-> (req_out == '0)); // R2
endmodule

// File: rtl/bypass_slot_shift.sv
module bypass_slot_shift #(
  parameter int HPC_MAX = 4,
  localparam int VW     = HPC_MAX - 1,
  localparam int SLOTS  = HPC_MAX - 1,
  localparam int SW     = SLOTS * VW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SW-1:0]    slots_in,
  input  logic [VW-1:0]    new_req,
  output logic [SW-1:0]    slots_out,
  output logic [SLOTS-1:0] msbs
);
  assign slots_out[0 +: VW] = new_req;

  for (genvar k = 0; k < SLOTS; k++) begin : g_msb
    assign msbs[k] = slots_in[k*VW + VW - 1];
  end

  for (genvar k = 1; k < SLOTS; k++) begin : g_move
    assign slots_out[k*VW +: VW] = {slots_in[(k-1)*VW +: VW-1], 1'b0};

    AST_RELAY_LSB_ZERO: assert property (@(posedge clk) disable iff (rst)
      slots_out[k*VW] == 1'b0); // R3
    AST_IN_SLOT_LEGAL: assert property (@(posedge clk) disable iff (rst)
      slots_in[k*VW +: k] == '0); // R4
  end
endmodule

// File: rtl/bypass_arb.sv
module bypass_arb #(
  parameter int HPC_MAX = 4,
  localparam int SLOTS  = HPC_MAX - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SLOTS-1:0] msbs,
  input  logic             free_vc,
  input  logic             local_req,
  output logic             flag
);
  logic want_pass;
  assign want_pass = |msbs;

  always_ff @(posedge clk) begin
    if (rst)
      flag <= 1'b0;
    else
      flag <= want_pass && free_vc && !local_req;
  end

  AST_FLAG_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    flag |-> $past(want_pass)); // R8
  AST_LOCAL_PRIO: assert property (@(posedge clk) disable iff (rst)
    local_req |=> !flag); // R6
  AST_NEEDS_VC: assert property (@(posedge clk) disable iff (rst)
    !free_vc |=> !flag); // R7
endmodule

// File: rtl/bypass_ctrl.sv
module bypass_ctrl #(
  parameter int HPC_MAX = 4,
  parameter int HOP_W   = 4,
  parameter int NDIR    = bypass_pkg::NUM_DIRS,
  localparam int VW     = HPC_MAX - 1,
  localparam int SLOTS  = HPC_MAX - 1,
  localparam int SW     = SLOTS * VW
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NDIR*SW-1:0]    ssr_in,
  input  logic [NDIR-1:0]       win_valid,
  input  logic [NDIR*HOP_W-1:0] hops_left,
  input  logic [NDIR-1:0]       local_req,
  input  logic [NDIR-1:0]       free_vc,
  output logic [NDIR*SW-1:0]    ssr_out,
  output logic [NDIR-1:0]       bypass_flag
);
  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    logic [VW-1:0]    gen_req;
    logic [SLOTS-1:0] in_msbs;

    bypass_req_gen #(.HPC_MAX(HPC_MAX), .HOP_W(HOP_W)) u_gen (
      .clk       (clk),
      .rst       (rst),
      .win_valid (win_valid[d]),
      .hops_left (hops_left[d*HOP_W +: HOP_W]),
      .req_out   (gen_req)
    );

    bypass_slot_shift #(.HPC_MAX(HPC_MAX)) u_shift (
      .clk       (clk),
      .rst       (rst),
      .slots_in  (ssr_in[d*SW +: SW]),
      .new_req   (gen_req),
      .slots_out (ssr_out[d*SW +: SW]),
      .msbs      (in_msbs)
    );

    bypass_arb #(.HPC_MAX(HPC_MAX)) u_arb (
      .clk       (clk),
      .rst       (rst),
      .msbs      (in_msbs),
      .free_vc   (free_vc[d]),
      .local_req (local_req[d]),
      .flag      (bypass_flag[d])
    );
  end

  AST_RESET_FLAGS: assert property (@(posedge clk)
    rst |=> (bypass_flag == '0)); // R9
endmodule

// File: tb/tb_bypass_ctrl.sv
module tb_bypass_ctrl;
  localparam int CLK_P = 10;
  localparam int HPC   = 4;
  localparam int HW    = 4;
  localparam int ND    = 4;
  localparam int VW    = HPC - 1;
  localparam int SW    = VW * VW;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ND*SW-1:0]  ssr_in = '0;
  logic [ND-1:0]     win_valid = '0;
  logic [ND*HW-1:0]  hops_left = '0;
  logic [ND-1:0]     local_req = '0;
  logic [ND-1:0]     free_vc = '0;
  logic [ND*SW-1:0]  ssr_out;
  logic [ND-1:0]     bypass_flag;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  bypass_ctrl #(.HPC_MAX(HPC), .HOP_W(HW), .NDIR(ND)) dut (
    .clk(clk), .rst(rst), .ssr_in(ssr_in), .win_valid(win_valid),
    .hops_left(hops_left), .local_req(local_req), .free_vc(free_vc),
    .ssr_out(ssr_out), .bypass_flag(bypass_flag)
  );

  function automatic logic [VW-1:0] exp_req(input bit win, input int hops);
    int n;
    logic [VW-1:0] r;
    if (!win || hops == 0) n = 0;
    else if (hops >= HPC)  n = VW;
    else                   n = hops - 1;
    r = '0;
    for (int i = 0; i < n; i++) r[VW-1-i] = 1'b1;
    return r;
  endfunction

  function automatic logic [SW-1:0] exp_slots(input logic [SW-1:0] sin,
                                              input logic [VW-1:0] nreq);
    logic [SW-1:0] o;
    o[0 +: VW] = nreq;
    for (int k = 1; k < VW; k++)
      o[k*VW +: VW] = sin[(k-1)*VW +: VW] << 1;
    return o;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_inputs();
    ssr_in = '0; win_valid = '0; hops_left = '0; local_req = '0; free_vc = '0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    clear_inputs();
    free_vc = '1;
    ssr_in = {ND{9'b000_000_100}};
    repeat (3) @(negedge clk);
    chk(bypass_flag == '0, "R9 flags after reset", 64'(bypass_flag), 0);
    rst = 1'b0;
    clear_inputs();
    @(negedge clk);
  endtask

  task automatic t_gen();
    for (int h = 0; h < 8; h++) begin
      clear_inputs();
      win_valid[0] = 1'b1;
      hops_left[0 +: HW] = HW'(h);
      #1;
      chk(ssr_out[0 +: VW] == exp_req(1'b1, h), "R1 request for hop count",
          64'(ssr_out[0 +: VW]), 64'(exp_req(1'b1, h)));
      @(negedge clk);
    end
  endtask

  task automatic t_nowin();
    clear_inputs();
    hops_left = {ND{4'd5}};
    ssr_in = {ND{9'b100_110_111}};
    #1;
    for (int d = 0; d < ND; d++)
      chk(ssr_out[d*SW +: VW] == '0, "R2 slot0 zero without winner",
          64'(ssr_out[d*SW +: VW]), 0);
    @(negedge clk);
  endtask

  task automatic t_shift(input logic [SW-1:0] pat, input int hops);
    clear_inputs();
    ssr_in[0 +: SW] = pat;
    win_valid[0] = 1'b1;
    hops_left[0 +: HW] = HW'(hops);
    #1;
    chk(ssr_out[0 +: SW] == exp_slots(pat, exp_req(1'b1, hops)),
        "R3 slot relay and bit shift", 64'(ssr_out[0 +: SW]),
        64'(exp_slots(pat, exp_req(1'b1, hops))));
    @(negedge clk);
  endtask

  task automatic t_drop();
    clear_inputs();
    ssr_in[0 +: SW] = 9'b100_000_000;
    free_vc[0] = 1'b1;
    #1;
    chk(ssr_out[0 +: SW] == '0, "R4 farthest slot dropped",
        64'(ssr_out[0 +: SW]), 0);
    @(negedge clk);
    chk(bypass_flag[0] == 1'b1, "R4 farthest slot MSB still used",
        64'(bypass_flag[0]), 1);
  endtask

  task automatic t_flag(input logic [SW-1:0] pat, input bit vc, input bit loc,
                        input bit exp, input string tag);
    clear_inputs();
    ssr_in[0 +: SW] = pat;
    free_vc[0] = vc;
    local_req[0] = loc;
    @(negedge clk);
    chk(bypass_flag[0] == exp, tag, 64'(bypass_flag[0]), 64'(exp));
  endtask

  task automatic t_dirs();
    for (int d = 0; d < ND; d++) begin
      clear_inputs();
      ssr_in[d*SW +: SW] = 9'b000_100_110;
      win_valid[d] = 1'b1;
      hops_left[d*HW +: HW] = 4'd3;
      free_vc = '1;
      #1;
      for (int e = 0; e < ND; e++) begin
        logic [SW-1:0] ex;
        ex = (e == d) ? exp_slots(9'b000_100_110, 3'b110) : '0;
        chk(ssr_out[e*SW +: SW] == ex, "R10 slots per direction",
            64'(ssr_out[e*SW +: SW]), 64'(ex));
      end
      @(negedge clk);
      chk(bypass_flag == ND'(1 << d), "R10 flag per direction",
          64'(bypass_flag), 64'(1 << d));
    end
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_gen();
    t_nowin();
    t_shift(9'b000_000_110, 3);
    t_shift(9'b100_110_011, 1);
    t_shift(9'b100_010_111, 9);
    t_drop();
    t_flag(9'b000_000_100, 1'b1, 1'b0, 1'b1, "R5 slot0 MSB passes");
    t_flag(9'b000_100_000, 1'b1, 1'b0, 1'b1, "R5 slot1 MSB passes");
    t_flag(9'b000_100_100, 1'b1, 1'b1, 1'b0, "R6 local flit wins");
    t_flag(9'b100_000_100, 1'b0, 1'b0, 1'b0, "R7 no free VC");
    t_flag(9'b000_010_011, 1'b1, 1'b0, 1'b0, "R8 no MSB set");
    t_flag(9'b000_000_000, 1'b1, 1'b0, 1'b0, "R8 all slots empty");
    t_dirs();
    clear_inputs();
    @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule